// File: doc/BRIEF.md
# Exclusive Reservation Monitor with Event Wake

This block sits between several cores and a small shared word memory. It gives them the two primitives that lock code is built on. The first is a load-linked / store-conditional pair: a load-exclusive reads a word and leaves a reservation for the issuing core. The matching store-exclusive writes only if nothing has broken that reservation, and it reports the outcome as a status bit. The second is a low-power wait: a core that issues wait-for-event sleeps until some core broadcasts a send-event.

Each core has one request channel. A single request is granted per cycle, with fixed priority to the lowest core index. Every memory write goes out on one internal write bus, and each core's reservation slot snoops that bus. A write by a different core anywhere inside the reserved granule (2^GRAN_LOG2 aligned words) clears the reservation. A granted request produces a one-cycle response on the following cycle. A sleeping core gets its response when an event wakes it.

Top module: `excl_mon`

## Requirements
- R1: After reset no response is valid, no core is asleep, every memory word reads zero and no core holds a reservation (a store-exclusive at once returns status 1).
- R2: A request granted at a clock edge produces rsp_valid for that core for exactly the next cycle; load (op 0) and load-exclusive (op 2) return the addressed word in rsp_rdata.
- R3: A store-exclusive (op 3) whose core holds a valid reservation on the addressed granule writes the word and returns status 0.
- R4: If a different core writes any word of the reserved granule, with a plain store (op 1) or a successful store-exclusive, between the load-exclusive and the store-exclusive, the store-exclusive returns status 1 and does not write.
- R5: Every store-exclusive clears the issuing core's reservation, whether it succeeds or fails, so a second store-exclusive without a new load-exclusive fails.
- R6: A store-exclusive to a granule other than the reserved one returns status 1 and leaves memory unchanged.
- R7: Reservations cover an aligned granule of 2^GRAN_LOG2 words (default two). A store-exclusive to any word of that granule can succeed. A write by another core to a word outside the granule leaves the reservation intact.
- R8: A wait-for-event (op 4) with no pending event puts the core to sleep (core_asleep high, no response, never granted). A send-event (op 5) from any core wakes every sleeping core, and each of them gets a response two cycles after the send-event is granted.
- R9: Every send-event also sets a pending-event flag in every core. A wait-for-event that finds its own flag set responds on the next cycle without sleeping and clears the flag, so a following wait-for-event sleeps.
- R10: At most one request is granted per cycle, and the grant goes to the lowest-indexed live request. req_ready is high only for the granted core.
- R11: Op codes 6 and 7 are accepted with status 1 and change neither memory nor any reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CORES | Request present, one bit per core |
| req_ready | output | N_CORES | Request granted this cycle |
| req_op | input | 3*N_CORES | Operation per core: 0 load, 1 store, 2 load-excl, 3 store-excl, 4 wait-event, 5 send-event |
| req_addr | input | AW*N_CORES | Word address per core |
| req_wdata | input | DW*N_CORES | Store data per core |
| rsp_valid | output | N_CORES | One-cycle response strobe per core |
| rsp_rdata | output | DW*N_CORES | Word read at grant |
| rsp_status | output | N_CORES | 0 success, 1 failure |
| core_asleep | output | N_CORES | Core is waiting for an event |

## Verification
On every cycle the assertions check the arbitration: a single grant, the lowest live index wins, and no sleeping core is granted. They also check that each granted non-wait request, and each wake-up, leads to a response, and that a store-exclusive's status bit matches whether its reservation still held. The bench scenarios are needed to show what the memory ends up holding. They also show the sequences that decide a reservation across several requests: a snooped write from another core, a repeated store-exclusive, a store inside or outside the granule, and the pending-flag and broadcast-wake behaviour of the event mechanism.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_LD  = 3'd0,
      OP_ST  = 3'd1,
      OP_LDX = 3'd2,
      OP_STX = 3'd3,
      OP_WFE = 3'd4,
      OP_SEV = 3'd5
   } op_e;

endpackage

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
   parameter int N_CORES = 3
) (
   input  logic [N_CORES-1:0] req,
   output logic [N_CORES-1:0] gnt
);

   // fixed priority: the lowest index wins
   logic [N_CORES-1:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar i = 1; i < N_CORES; i++) begin : g_chain
      assign blocked[i] = blocked[i-1] | req[i-1];
   end

   assign gnt = req & ~blocked;

endmodule

// File: rtl/excl_mon_resv.sv
module excl_mon_resv #(
   parameter int GW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ldx_set,
   input  logic          stx_clr,
   input  logic          snoop_we,
   input  logic          snoop_own,
   input  logic [GW-1:0] gran,
   output logic          hit
);

   logic          held;
   logic [GW-1:0] held_gran;
   logic          same;

   assign same = (held_gran == gran);
   assign hit  = held & same;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_gran <= '0;
      end else if (ldx_set) begin
         held      <= 1'b1;
         held_gran <= gran;
      end else if (stx_clr) begin
         held <= 1'b0;
      end else if (snoop_we && !snoop_own && same) begin
         held <= 1'b0;
      end
   end

endmodule

// File: rtl/excl_mon_evt.sv
module excl_mon_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic sev,
   input  logic wfe_go,
   output logic asleep,
   output logic done
);

   logic flag;

   assign done = flag & (wfe_go | asleep);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         asleep <= 1'b0;
      end else begin
         if (sev)       flag <= 1'b1;
         else if (done) flag <= 1'b0;

         if (done)        asleep <= 1'b0;
         else if (wfe_go) asleep <= 1'b1;
      end
   end

endmodule

// File: rtl/excl_mon.sv
module excl_mon
   import excl_mon_pkg::*;
#(
   parameter int N_CORES   = 3,
   parameter int AW        = 5,
   parameter int DW        = 32,
   parameter int GRAN_LOG2 = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_CORES-1:0]      req_valid,
   output logic [N_CORES-1:0]      req_ready,
   input  logic [N_CORES*OP_W-1:0] req_op,
   input  logic [N_CORES*AW-1:0]   req_addr,
   input  logic [N_CORES*DW-1:0]   req_wdata,
   output logic [N_CORES-1:0]      rsp_valid,
   output logic [N_CORES*DW-1:0]   rsp_rdata,
   output logic [N_CORES-1:0]      rsp_status,
   output logic [N_CORES-1:0]      core_asleep
);

   localparam int DEPTH = 1 << AW;
   localparam int GW    = AW - GRAN_LOG2;

   if (N_CORES < 2) begin : g_bad_cores
      $error("excl_mon needs at least two cores");
   end
   if (GRAN_LOG2 < 0 || GRAN_LOG2 >= AW) begin : g_bad_gran
      $error("excl_mon granule must be smaller than the address space");
   end
   if (DW < 1) begin : g_bad_dw
      $error("excl_mon data width must be positive");
   end

   logic [N_CORES-1:0] live;
   logic [N_CORES-1:0] gnt;
   logic [N_CORES-1:0] asleep;
   logic [N_CORES-1:0] evt_done;
   logic [N_CORES-1:0] resv_hit;

   logic [OP_W-1:0]    gop;
   logic [AW-1:0]      gword;
   logic [GW-1:0]      ggran;
   logic [DW-1:0]      gwdata;
   logic               gnt_any;
   logic               stx_go;
   logic               stx_hit;
   logic               mem_we;
   logic               sev_go;
   logic               op_legal;
   logic               status_now;

   logic [DW-1:0]      mem [DEPTH];

   assign live = req_valid & ~asleep;

   excl_mon_arb #(.N_CORES(N_CORES)) u_arb (
      .req (live),
      .gnt (gnt)
   );

   assign req_ready = gnt;

   always_comb begin
      gop    = '0;
      gword  = '0;
      gwdata = '0;
      for (int i = 0; i < N_CORES; i++) begin
         if (gnt[i]) begin
            gop    = req_op[i*OP_W +: OP_W];
            gword  = req_addr[i*AW +: AW];
            gwdata = req_wdata[i*DW +: DW];
         end
      end
   end

   assign ggran      = gword[AW-1:GRAN_LOG2];
   assign gnt_any    = |gnt;
   assign stx_go     = gnt_any && (gop == OP_STX);
   assign stx_hit    = |(resv_hit & gnt);
   assign sev_go     = gnt_any && (gop == OP_SEV);
   assign op_legal   = (gop <= OP_SEV);
   assign mem_we     = gnt_any && ((gop == OP_ST) || (stx_go && stx_hit));
   assign status_now = (gop == OP_STX) ? !stx_hit : !op_legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      end else if (mem_we) begin
         mem[gword] <= gwdata;
      end
   end

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      logic          wfe_go;
      logic          v_q;
      logic          s_q;
      logic [DW-1:0] d_q;

      assign wfe_go = gnt[c] && (gop == OP_WFE);

      excl_mon_resv #(.GW(GW)) u_resv (
         .clk       (clk),
         .rst_n     (rst_n),
         .ldx_set   (gnt[c] && (gop == OP_LDX)),
         .stx_clr   (gnt[c] && (gop == OP_STX)),
         .snoop_we  (mem_we),
         .snoop_own (gnt[c]),
         .gran      (ggran),
         .hit       (resv_hit[c])
      );

      excl_mon_evt u_evt (
         .clk    (clk),
         .rst_n  (rst_n),
         .sev    (sev_go),
         .wfe_go (wfe_go),
         .asleep (asleep[c]),
         .done   (evt_done[c])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= (gnt[c] && !wfe_go) || evt_done[c];
            if (gnt[c]) begin
               s_q <= wfe_go ? 1'b0 : status_now;
               d_q <= mem[gword];
            end else if (evt_done[c]) begin
               s_q <= 1'b0;
            end
         end
      end

      assign rsp_valid[c]            = v_q;
      assign rsp_status[c]           = s_q;
      assign rsp_rdata[c*DW +: DW]   = d_q;
   end

   assign core_asleep = asleep;

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk
   import excl_mon_pkg::*;
#(
   parameter int N_CORES = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_CORES-1:0] req_valid,
   input logic [N_CORES-1:0] gnt,
   input logic [N_CORES-1:0] asleep,
   input logic [N_CORES-1:0] rsp_valid,
   input logic [N_CORES-1:0] rsp_status,
   input logic [OP_W-1:0]    gop,
   input logic               stx_hit
);

   assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   for (genvar i = 0; i < N_CORES; i++) begin : g_chk
      localparam logic [N_CORES-1:0] LOWER = (N_CORES'(1) << i) - N_CORES'(1);

      assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
         gnt[i] |-> ((req_valid & ~asleep & LOWER) == '0));

      assert_sleeper_not_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
         asleep[i] |-> !gnt[i]);

      assert_wake_responds_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(asleep[i]) |-> rsp_valid[i]);

      assert_grant_responds_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt[i] && (gop != OP_WFE)) |=> rsp_valid[i]);

      assert_stx_broken_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt[i] && (gop == OP_STX) && !stx_hit) |=> rsp_status[i]);

      assert_stx_held_succeeds_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt[i] && (gop == OP_STX) && stx_hit) |=> !rsp_status[i]);
   end

endmodule

bind excl_mon excl_mon_chk #(.N_CORES(N_CORES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .gnt        (gnt),
   .asleep     (asleep),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .gop        (gop),
   .stx_hit    (stx_hit)
);

// File: tb/excl_mon_bench.sv
module excl_mon_bench;

   localparam int N  = 3;
   localparam int AW = 5;
   localparam int DW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [N-1:0]    req_ready;
   logic [N*3-1:0]  req_op = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic [N*DW-1:0] req_wdata = '0;
   logic [N-1:0]    rsp_valid;
   logic [N*DW-1:0] rsp_rdata;
   logic [N-1:0]    rsp_status;
   logic [N-1:0]    core_asleep;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   excl_mon #(.N_CORES(N), .AW(AW), .DW(DW), .GRAN_LOG2(1)) u_excl_mon (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_status(rsp_status), .core_asleep(core_asleep)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input int c, input logic [2:0] op, input int a, input logic [31:0] d);
      req_valid[c]          = 1'b1;
      req_op[c*3 +: 3]      = op;
      req_addr[c*AW +: AW]  = AW'(a);
      req_wdata[c*DW +: DW] = d;
   endtask

   // one request, sampled half a cycle after its grant edge
   task automatic do_op(input int c, input logic [2:0] op, input int a, input logic [31:0] d,
                        output logic v, output logic [31:0] rd, output logic st);
      @(negedge clk);
      drive(c, op, a, d);
      @(posedge clk);
      @(negedge clk);
      v  = rsp_valid[c];
      rd = rsp_rdata[c*DW +: DW];
      st = rsp_status[c];
      req_valid[c] = 1'b0;
   endtask

   task automatic rd_word(input int c, input int a, output logic [31:0] rd);
      logic v, st;
      do_op(c, 3'd0, a, 0, v, rd, st);
   endtask

   task automatic t_reset();
      logic v, st; logic [31:0] rd;
      chk("R1 rsp_valid", 32'(rsp_valid), 0);
      chk("R1 asleep", 32'(core_asleep), 0);
      rd_word(0, 4, rd);
      chk("R1 mem zero", rd, 0);
      do_op(0, 3'd3, 8, 32'h5, v, rd, st);
      chk("R1 stx without reservation", 32'(st), 1);
      rd_word(0, 8, rd);
      chk("R1 stx wrote nothing", rd, 0);
   endtask

   task automatic t_basic();
      logic v, st; logic [31:0] rd;
      do_op(0, 3'd1, 16, 32'hA5, v, rd, st);
      chk("R2 store responds", 32'(v), 1);
      @(negedge clk);
      chk("R2 response lasts one cycle", 32'(rsp_valid[0]), 0);
      do_op(0, 3'd2, 16, 0, v, rd, st);
      chk("R2 ldx data", rd, 32'hA5);
      do_op(0, 3'd3, 16, 32'h11, v, rd, st);
      chk("R3 stx status", 32'(st), 0);
      rd_word(1, 16, rd);
      chk("R3 stx wrote", rd, 32'h11);
      do_op(0, 3'd3, 16, 32'h22, v, rd, st);
      chk("R5 second stx fails", 32'(st), 1);
      rd_word(1, 16, rd);
      chk("R5 no write", rd, 32'h11);
   endtask

   task automatic t_conflict();
      logic v, st; logic [31:0] rd;
      do_op(0, 3'd2, 20, 0, v, rd, st);
      do_op(1, 3'd1, 20, 32'h77, v, rd, st);
      do_op(0, 3'd3, 20, 32'h99, v, rd, st);
      chk("R4 snooped store breaks stx", 32'(st), 1);
      rd_word(0, 20, rd);
      chk("R4 memory keeps other write", rd, 32'h77);
      // two cores race with store-exclusive
      do_op(0, 3'd2, 24, 0, v, rd, st);
      do_op(1, 3'd2, 24, 0, v, rd, st);
      do_op(1, 3'd3, 24, 32'h1, v, rd, st);
      chk("R3 first stx wins", 32'(st), 0);
      do_op(0, 3'd3, 24, 32'h2, v, rd, st);
      chk("R4 loser stx fails", 32'(st), 1);
      rd_word(2, 24, rd);
      chk("R4 loser did not write", rd, 32'h1);
   endtask

   task automatic t_granule();
      logic v, st; logic [31:0] rd;
      do_op(0, 3'd2, 12, 0, v, rd, st);
      do_op(1, 3'd1, 14, 32'h5, v, rd, st);
      do_op(0, 3'd3, 13, 32'h66, v, rd, st);
      chk("R7 same-granule stx succeeds", 32'(st), 0);
      rd_word(0, 13, rd);
      chk("R7 granule write", rd, 32'h66);
      do_op(2, 3'd2, 10, 0, v, rd, st);
      do_op(1, 3'd1, 11, 32'h1, v, rd, st);
      do_op(2, 3'd3, 10, 32'h3, v, rd, st);
      chk("R7 write to partner word breaks", 32'(st), 1);
   endtask

   task automatic t_wrong_addr();
      logic v, st; logic [31:0] rd;
      do_op(1, 3'd2, 6, 0, v, rd, st);
      do_op(1, 3'd3, 28, 32'hBB, v, rd, st);
      chk("R6 wrong granule fails", 32'(st), 1);
      rd_word(1, 28, rd);
      chk("R6 no write", rd, 0);
      do_op(1, 3'd3, 6, 32'hCC, v, rd, st);
      chk("R5 reservation cleared by failed stx", 32'(st), 1);
   endtask

   task automatic t_priority();
      @(negedge clk);
      drive(1, 3'd0, 16, 0);
      drive(2, 3'd0, 20, 0);
      #1;
      chk("R10 lower index ready", 32'(req_ready), 32'b010);
      @(posedge clk);
      @(negedge clk);
      chk("R10 only core1 responds", 32'(rsp_valid), 32'b010);
      chk("R10 core1 data", rsp_rdata[1*DW +: DW], 32'h11);
      req_valid[1] = 1'b0;
      #1;
      chk("R10 core2 now ready", 32'(req_ready), 32'b100);
      @(posedge clk);
      @(negedge clk);
      chk("R10 core2 responds", 32'(rsp_valid), 32'b100);
      chk("R10 core2 data", rsp_rdata[2*DW +: DW], 32'h77);
      req_valid[2] = 1'b0;
   endtask

   task automatic t_illegal();
      logic v, st; logic [31:0] rd;
      do_op(0, 3'd2, 30, 0, v, rd, st);
      do_op(1, 3'd7, 30, 32'hEE, v, rd, st);
      chk("R11 unknown op status", 32'(st), 1);
      chk("R11 unknown op responds", 32'(v), 1);
      rd_word(2, 30, rd);
      chk("R11 memory unchanged", rd, 0);
      do_op(0, 3'd3, 30, 32'h4, v, rd, st);
      chk("R11 reservation untouched", 32'(st), 0);
   endtask

   task automatic t_events();
      logic v, st; logic [31:0] rd;
      do_op(1, 3'd4, 0, 0, v, rd, st);
      chk("R8 wfe sleeps no response", 32'(v), 0);
      do_op(2, 3'd4, 0, 0, v, rd, st);
      chk("R8 both asleep", 32'(core_asleep), 32'b110);
      @(negedge clk);
      drive(1, 3'd0, 0, 0);
      #1;
      chk("R8 sleeper not ready", 32'(req_ready[1]), 0);
      req_valid[1] = 1'b0;
      do_op(0, 3'd5, 0, 0, v, rd, st);
      chk("R8 sev responds", 32'(v), 1);
      @(negedge clk);
      chk("R8 wake responses", 32'(rsp_valid), 32'b110);
      chk("R8 awake", 32'(core_asleep), 0);
      do_op(0, 3'd4, 0, 0, v, rd, st);
      chk("R9 pending flag returns at once", 32'(v), 1);
      chk("R9 not asleep", 32'(core_asleep[0]), 0);
      do_op(0, 3'd4, 0, 0, v, rd, st);
      chk("R9 flag consumed, sleeps", 32'(core_asleep[0]), 1);
      do_op(2, 3'd5, 0, 0, v, rd, st);
      @(negedge clk);
      chk("R8 woken by other core", 32'(rsp_valid[0]), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_conflict();
      t_granule();
      t_wrong_addr();
      t_priority();
      t_illegal();
      t_events();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule